// File: doc/BRIEF.md
# RDS Block Serial Output Formatter

This block sits after the error detection and correction stage of a radio data receiver. Each processed 26-bit block arrives as a single-cycle handshake. The handshake carries the 16 data bits, an error flag, a corrected flag, the group-type bit and the 2-bit position of the block within its group. The block holds each block until the next one arrives and then shifts the held block out as a 24-bit frame. The frame goes out on a serial data pin, beside a generated serial clock whose active edge is chosen once after reset. The output therefore always runs one block behind the input.

A data-start output marks the first bit period of a frame. It fires on every block or only on second-position blocks, as a start-control input selects. The start-control input and a correction-enable input are both debounced before use. Before group sync is reached, a new level is taken after four identical samples, one sample per input bit strobe. After sync, a new level is taken after four identical samples, one sample per received block. The filtered correction-enable is passed back to the correction stage.

Top module: `rds_blk_tx`

## Requirements
- R1: During and after synchronous reset, and before any frame is sent, `ser_data` is 1, `data_start` is 1, `ser_clk` is 0 and `corr_en_o` is 0.
- R2: A frame is 24 bits, sent in this order: bit 0 is the start bit (0); bit 1 is `blk_err`; bit 2 is `blk_cor`; bits 3 and 4 are 0; bit 5 is `blk_grp`; bit 6 is `blk_idx[1]`; bit 7 is `blk_idx[0]`; bits 8 to 23 are `blk_data[0]` up to `blk_data[15]`.
- R3: The first block after reset produces no frame. Every later `blk_valid` starts, on the same clock edge, the frame of the block held from the previous `blk_valid`, and then stores the new block.
- R4: Each bit lasts 2*HALF_PER cycles. In the first half, `ser_clk` equals the latched polarity and `ser_data` takes the new bit. In the second half, `ser_clk` is inverted, so data is stable across the active edge.
- R5: `clk_pol_in` is sampled once, exactly POL_DELAY clock edges after reset is released, and is held until the next reset. Later changes of `clk_pol_in` have no effect on `ser_clk`.
- R6: With filtered start-control at 1, `data_start` is 1 for the first 2*HALF_PER cycles of every frame and 0 for the rest of the frame and the idle time after it.
- R7: With filtered start-control at 0, `data_start` rises only for frames whose block index is 1; frames of any other index leave it at 0.
- R8: While `synced` is 0, each mode input is sampled on `in_clk_stb`. The filtered level changes on the 4th successive sample that differs from it. A sample equal to the current level restarts the count.
- R9: While `synced` is 1, each mode input is sampled only on `blk_valid`, with the same four-sample rule as R8. `in_clk_stb` has no effect on the filtered level.
- R10: When a frame ends, `ser_data` returns to 1 and `ser_clk` rests at the latched polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_clk_stb | input | 1 | One-cycle strobe per received input bit |
| synced | input | 1 | Group sync reached |
| blk_valid | input | 1 | One-cycle strobe: a processed block is presented |
| blk_data | input | DATA_W | Block data bits |
| blk_err | input | 1 | Block was not correctable |
| blk_cor | input | 1 | Block was corrected |
| blk_grp | input | 1 | Group type bit |
| blk_idx | input | 2 | Block position in group (0 to 3) |
| corr_en_in | input | 1 | Raw correction-enable mode input |
| start_ctl_in | input | 1 | Raw start-control mode input (1 every block, 0 second block only) |
| clk_pol_in | input | 1 | Serial clock polarity select |
| ser_data | output | 1 | Serial frame data |
| ser_clk | output | 1 | Generated serial clock |
| data_start | output | 1 | Frame start marker |
| corr_en_o | output | 1 | Filtered correction-enable |

## Verification
The bench builds the block with HALF_PER=2 and POL_DELAY=40. With these values a frame takes 96 cycles and the polarity latch happens early in the run. This allows many full frames, both data-start modes, both debounce regimes and a polarity change after the latch point to fit into a short run. A frame that starts while the previous one is still running is never driven, so the abort path is left to the assertions.

// File: rtl/rds_blk_tx_pkg.sv
package rds_blk_tx_pkg;
  localparam int HDR_W = 8;

  function automatic logic [HDR_W+16-1:0] make_frame16(
    input logic        err,
    input logic        cor,
    input logic        grp,
    input logic [1:0]  idx,
    input logic [15:0] dat
  );
    logic [HDR_W+16-1:0] f;
    f      = '0;
    f[0]   = 1'b0;    // start bit
    f[1]   = err;
    f[2]   = cor;
    f[3]   = 1'b0;
    f[4]   = 1'b0;
    f[5]   = grp;
    f[6]   = idx[1];
    f[7]   = idx[0];
    f[HDR_W +: 16] = dat;
    return f;
  endfunction
endpackage

// File: rtl/rds_pol_latch.sv
module rds_pol_latch #(
  parameter int POL_DELAY = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic pol_in,
  output logic pol_q
);
  localparam int CW = $clog2(POL_DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(POL_DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) begin
        pol_q  <= pol_in;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_POL_HELD: assert property (@(posedge clk) disable iff (rst)
    (done_q && $past(done_q)) |-> $stable(pol_q)); // R5
endmodule

// File: rtl/rds_mode_filter.sv
module rds_mode_filter #(
  parameter int STABLE_N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_ev,
  input  logic raw,
  output logic lvl_q
);
  localparam int CW = $clog2(STABLE_N + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_N - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (smp_ev) begin
      if (raw == lvl_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        run_q <= '0;
        lvl_q <= raw;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  AST_FLIP_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl_q) |-> $past(smp_ev)); // R8
endmodule

// File: rtl/rds_frame_shifter.sv
module rds_frame_shifter #(
  parameter int FRAME_W  = 24,
  parameter int HALF_PER = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame,
  input  logic               mark,
  input  logic               pol,
  output logic               ser_data,
  output logic               ser_clk,
  output logic               start_mark
);
  localparam int DW = $clog2(HALF_PER + 1);
  localparam int BW = $clog2(FRAME_W + 1);
  localparam logic [DW-1:0] DLAST = DW'(HALF_PER - 1);
  localparam logic [BW-1:0] BLAST = BW'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [DW-1:0]      div_q;
  logic [BW-1:0]      bit_q;
  logic               busy_q;
  logic               ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      div_q      <= '0;
      bit_q      <= '0;
      busy_q     <= 1'b0;
      ph_q       <= 1'b0;
      ser_data   <= 1'b1;
      start_mark <= 1'b1;
    end else if (go) begin
      sh_q       <= frame;
      div_q      <= '0;
      bit_q      <= '0;
      busy_q     <= 1'b1;
      ph_q       <= 1'b0;
      ser_data   <= frame[0];
      start_mark <= mark;
    end else if (busy_q) begin
      if (div_q == DLAST) begin
        div_q <= '0;
        if (!ph_q) begin
          ph_q <= 1'b1;
        end else begin
          ph_q <= 1'b0;
          if (bit_q == '0) start_mark <= 1'b0;
          if (bit_q == BLAST) begin
            busy_q   <= 1'b0;
            ser_data <= 1'b1;
          end else begin
            bit_q    <= bit_q + 1'b1;
            sh_q     <= sh_q >> 1;
            ser_data <= sh_q[1];
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign ser_clk = pol ^ ph_q;

  AST_STABLE_AT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_q) |-> $stable(ser_data)); // R4
  AST_IDLE_DATA_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ser_data); // R10
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (bit_q <= BLAST)); // R2
endmodule

// File: rtl/rds_blk_tx.sv
module rds_blk_tx
  import rds_blk_tx_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int HALF_PER  = 4,
  parameter int POL_DELAY = 4000,
  parameter int STABLE_N  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_clk_stb,
  input  logic              synced,
  input  logic              blk_valid,
  input  logic [DATA_W-1:0] blk_data,
  input  logic              blk_err,
  input  logic              blk_cor,
  input  logic              blk_grp,
  input  logic [1:0]        blk_idx,
  input  logic              corr_en_in,
  input  logic              start_ctl_in,
  input  logic              clk_pol_in,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              data_start,
  output logic              corr_en_o
);
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int N_MODE  = 2;

  logic [FRAME_W-1:0] held_frame_q;
  logic [1:0]         held_idx_q;
  logic               held_v_q;
  logic               pol;
  logic               go;
  logic               mark;
  logic               smp_ev;
  logic [N_MODE-1:0]  mode_raw;
  logic [N_MODE-1:0]  mode_lvl;
  logic [15:0]        dat16;

  // Mode inputs: index 0 correction-enable, index 1 start-control.
  assign mode_raw = {start_ctl_in, corr_en_in};
  assign smp_ev   = synced ? blk_valid : in_clk_stb;

  generate
    for (genvar gi = 0; gi < N_MODE; gi++) begin : g_mode
      rds_mode_filter #(.STABLE_N(STABLE_N)) u_flt (
        .clk    (clk),
        .rst    (rst),
        .smp_ev (smp_ev),
        .raw    (mode_raw[gi]),
        .lvl_q  (mode_lvl[gi])
      );
    end
  endgenerate

  assign corr_en_o = mode_lvl[0];

  rds_pol_latch #(.POL_DELAY(POL_DELAY)) u_pol (
    .clk    (clk),
    .rst    (rst),
    .pol_in (clk_pol_in),
    .pol_q  (pol)
  );

  always_comb begin
    dat16 = '0;
    for (int i = 0; i < DATA_W && i < 16; i++) dat16[i] = blk_data[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_frame_q <= '0;
      held_idx_q   <= '0;
      held_v_q     <= 1'b0;
    end else if (blk_valid) begin
      held_frame_q <= FRAME_W'(make_frame16(blk_err, blk_cor, blk_grp, blk_idx, dat16));
      held_idx_q   <= blk_idx;
      held_v_q     <= 1'b1;
    end
  end

  assign go   = blk_valid && held_v_q;
  assign mark = mode_lvl[1] || (held_idx_q == 2'd1);

  rds_frame_shifter #(.FRAME_W(FRAME_W), .HALF_PER(HALF_PER)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .frame      (held_frame_q),
    .mark       (mark),
    .pol        (pol),
    .ser_data   (ser_data),
    .ser_clk    (ser_clk),
    .start_mark (data_start)
  );

  AST_START_ONLY_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(data_start) |-> $past(go)); // R6
  AST_NO_FRAME_FIRST: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !held_v_q) |=> $stable(ser_data)); // R3
  AST_SECOND_ONLY: assert property (@(posedge clk) disable iff (rst)
    (go && !mode_lvl[1] && held_idx_q != 2'd1) |=> !data_start); // R7
endmodule

// File: tb/rds_blk_tx_tb.sv
module rds_blk_tx_tb;
  localparam int CLK_PER = 10;
  localparam int HP = 2;
  localparam int PD = 40;
  localparam int FW = 24;
  localparam int FRAME_CYC = FW * 2 * HP;

  logic clk = 0, rst = 1;
  logic in_clk_stb = 0, synced = 0, blk_valid = 0;
  logic [15:0] blk_data = 0;
  logic blk_err = 0, blk_cor = 0, blk_grp = 0;
  logic [1:0] blk_idx = 0;
  logic corr_en_in = 0, start_ctl_in = 1, clk_pol_in = 1;
  logic ser_data, ser_clk, data_start, corr_en_o;

  int n_cmp = 0, n_bad = 0;
  string section = "R1";

  always #(CLK_PER/2) clk = ~clk;

  rds_blk_tx #(.DATA_W(16), .HALF_PER(HP), .POL_DELAY(PD), .STABLE_N(4)) u_dut (
    .clk(clk), .rst(rst), .in_clk_stb(in_clk_stb), .synced(synced),
    .blk_valid(blk_valid), .blk_data(blk_data), .blk_err(blk_err),
    .blk_cor(blk_cor), .blk_grp(blk_grp), .blk_idx(blk_idx),
    .corr_en_in(corr_en_in), .start_ctl_in(start_ctl_in), .clk_pol_in(clk_pol_in),
    .ser_data(ser_data), .ser_clk(ser_clk), .data_start(data_start), .corr_en_o(corr_en_o));

  // Reference model state
  bit m_started = 0;
  int m_edges, m_t;
  bit m_pol, m_pol_done, m_ds, m_held_v;
  bit m_frame[FW];
  bit m_held[FW];
  int m_held_idx;
  bit m_lvl[2];
  int m_run[2];

  always @(posedge clk) begin
    bit raw[2];
    bit ev;
    m_started = 1;
    if (rst) begin
      m_edges = 0; m_t = -1; m_pol = 0; m_pol_done = 0; m_ds = 1; m_held_v = 0;
      m_held_idx = 0;
      foreach (m_lvl[k]) begin m_lvl[k] = 0; m_run[k] = 0; end
    end else begin
      m_edges++;
      // R5: single sample of the polarity select
      if (!m_pol_done && m_edges == PD) begin m_pol = clk_pol_in; m_pol_done = 1; end
      // R3: frame of previous block starts on the next handshake
      if (blk_valid && m_held_v) begin
        m_frame = m_held; m_t = 0;
        m_ds = m_lvl[1] || (m_held_idx == 1); // R6 / R7
      end else if (m_t >= 0) begin
        m_t++;
        if (m_t == 2*HP) m_ds = 0;
        if (m_t == FRAME_CYC) m_t = -1;
      end
      if (blk_valid) begin
        m_held[0] = 0; m_held[1] = blk_err; m_held[2] = blk_cor;
        m_held[3] = 0; m_held[4] = 0; m_held[5] = blk_grp;
        m_held[6] = blk_idx[1]; m_held[7] = blk_idx[0];
        for (int i = 0; i < 16; i++) m_held[8+i] = blk_data[i];
        m_held_idx = blk_idx; m_held_v = 1;
      end
      // R8 / R9 mode filters
      raw[0] = corr_en_in; raw[1] = start_ctl_in;
      ev = synced ? blk_valid : in_clk_stb;
      if (ev) begin
        for (int k = 0; k < 2; k++) begin
          if (raw[k] == m_lvl[k]) m_run[k] = 0;
          else begin
            m_run[k]++;
            if (m_run[k] == 4) begin m_lvl[k] = raw[k]; m_run[k] = 0; end
          end
        end
      end
    end
  end

  task automatic chk(input string req, input string nm, input logic act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s actual=%b expected=%b t=%0t", req, section, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_started) begin
      bit e_d, e_c;
      e_d = (m_t < 0) ? 1'b1 : m_frame[m_t / (2*HP)];                 // R2, R10
      e_c = m_pol ^ ((m_t >= 0) && (((m_t / HP) % 2) == 1));          // R4, R5
      chk("R2", "ser_data", ser_data, e_d);
      chk("R4", "ser_clk", ser_clk, e_c);
      chk("R6", "data_start", data_start, m_ds);
      chk("R9", "corr_en_o", corr_en_o, m_lvl[0]);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int n);
    repeat (n) begin
      in_clk_stb = 1; tick(1); in_clk_stb = 0; tick(2);
    end
  endtask

  task automatic send(input logic [1:0] idx, input logic [15:0] d,
                      input logic e, input logic c, input logic g);
    blk_idx = idx; blk_data = d; blk_err = e; blk_cor = c; blk_grp = g;
    blk_valid = 1; tick(1); blk_valid = 0;
    tick(FRAME_CYC + 14);
  endtask

  task automatic run_all();
    tick(4); rst = 0;
    section = "R1"; tick(3);
    // R8: interrupted run of samples does not flip; four successive do
    section = "R8";
    strobe(3); start_ctl_in = 0; strobe(1); start_ctl_in = 1; strobe(3);
    strobe(1);
    tick(PD);
    // R5: change of the select after the latch point is ignored
    section = "R5"; clk_pol_in = 0; tick(5);
    // R2 R3 R6 R4 R10: frames with every block index, start mark on all
    section = "R3";
    send(2'd0, 16'h0001, 0, 0, 0);
    send(2'd1, 16'hA5C3, 0, 1, 1);
    send(2'd2, 16'h8000, 1, 0, 0);
    send(2'd3, 16'h7FFE, 0, 0, 1);
    send(2'd0, 16'hFFFF, 1, 1, 1);
    // R7: start mark only for index 1
    section = "R7"; start_ctl_in = 0; strobe(4);
    send(2'd1, 16'h1234, 0, 0, 0);
    send(2'd2, 16'h0F0F, 0, 1, 0);
    send(2'd3, 16'hF0F0, 0, 0, 1);
    send(2'd0, 16'h5555, 0, 0, 0);
    send(2'd1, 16'hAAAA, 1, 0, 1);
    // R9: after sync, strobes are ignored; four blocks flip the level
    section = "R9"; synced = 1; corr_en_in = 1; strobe(6);
    send(2'd2, 16'h0102, 0, 0, 0);
    send(2'd3, 16'h0304, 0, 0, 0);
    send(2'd0, 16'h0506, 0, 0, 0);
    send(2'd1, 16'h0708, 0, 0, 0);
    send(2'd2, 16'h090A, 0, 0, 0);
    tick(10);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all) actual=hung expected=finished");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule